// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block drives the request lines between a UART's transmit and receive FIFOs and a DMA controller. Each direction has its own single request and its own burst request. The block derives them from the FIFO occupancy counts, from a programmable trigger level per direction, and from the enable bits of a DMA control word. The serial datapath and the FIFO storage sit outside the block. The block sees the FIFOs only through their occupancy counts.

The block also keeps a small interrupt status word. Receive error pulses set bits in it, and completion strobes from the DMA controller set bits in it. Software clears the bits by write-one-to-clear. Any set bit drives the UART interrupt line. When the error-stop control bit is set, a pending receive error holds both receive request lines low until software clears the matching status bit. The transmit requests keep running during that time.

Top module: `uart_dma_req`

## Requirements
- R1: During and straight after reset, all request outputs, all status bits and `irq_o` are low.
- R2: When the UART and transmit DMA are enabled, `tx_single_o` is high exactly when `tx_count_i` is below the FIFO depth (16 by default), i.e. at least one slot is free.
- R3: When the UART and transmit DMA are enabled, `tx_burst_o` is high exactly when `tx_count_i` is strictly below the transmit threshold. Level codes 0,1,2,3,4 give thresholds of depth/8, depth/4, depth/2, 3·depth/4 and 7·depth/8 (2, 4, 8, 12, 14 at depth 16). Codes 5 to 7 act as code 4.
- R4: When the UART and receive DMA are enabled and the receive side is not blocked, `rx_single_o` is high exactly when `rx_count_i` is at least 1.
- R5: Under the same conditions, `rx_burst_o` is high exactly when `rx_count_i` is at or above the receive threshold. The receive threshold uses the same code mapping as R3.
- R6: `tx_dma_en_i` gates only the transmit requests and `rx_dma_en_i` gates only the receive requests. With `uart_en_i` low, all four requests are low.
- R7: A pulse on `rx_err_i` sets the matching bits 0 to 3 of `int_status_o`: bit 0 framing, bit 1 parity, bit 2 break, bit 3 overrun.
- R8: With `dma_on_err_i` high, the receive requests are low in the cycle an error is taken and for as long as any of status bits 0 to 3 stays set. The transmit requests are unaffected. With `dma_on_err_i` low, errors never block requests.
- R9: When `icr_we_i` is high, every status bit whose `icr_data_i` bit is 1 is cleared. A set event on the same bit in the same cycle wins over the clear.
- R10: `tx_done_i` sets status bit 4 and `rx_done_i` sets status bit 5. `irq_o` is the OR of all status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uart_en_i | input | 1 | UART enable |
| tx_dma_en_i | input | 1 | Transmit DMA enable |
| rx_dma_en_i | input | 1 | Receive DMA enable |
| dma_on_err_i | input | 1 | Stop receive DMA on receive error |
| tx_lvl_i | input | 3 | Transmit trigger level code |
| rx_lvl_i | input | 3 | Receive trigger level code |
| tx_count_i | input | CW (5) | Transmit FIFO occupancy |
| rx_count_i | input | CW (5) | Receive FIFO occupancy |
| rx_err_i | input | 4 | Error pulses: framing, parity, break, overrun |
| tx_done_i | input | 1 | Transmit DMA completion strobe |
| rx_done_i | input | 1 | Receive DMA completion strobe |
| icr_we_i | input | 1 | Interrupt clear write strobe |
| icr_data_i | input | 6 | Write-one-to-clear mask |
| tx_single_o | output | 1 | Transmit single request |
| tx_burst_o | output | 1 | Transmit burst request |
| rx_single_o | output | 1 | Receive single request |
| rx_burst_o | output | 1 | Receive burst request |
| int_status_o | output | 6 | Interrupt status |
| irq_o | output | 1 | UART interrupt line |

## Verification
Every output of this block is registered. Inputs sampled at one rising edge show up on the outputs right after that edge, so all results are due one cycle after the stimulus. The receive blocking and the status update are computed from the post-edge status, so they also arrive after one cycle, with no extra delay for errors or clears. The driver applies stimulus on the falling edge and pushes the expected output set into a queue. The monitor pops that entry just after the next rising edge and compares it field by field, so every expectation is compared against exactly one edge.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;
  localparam int unsigned ERR_W  = 4;
  localparam int unsigned STAT_W = 6;
  localparam int unsigned LVL_W  = 3;
  localparam int unsigned BIT_TX_DONE = 4;
  localparam int unsigned BIT_RX_DONE = 5;

  // Trigger threshold in entries for a level code.
  function automatic int unsigned lvl_thresh(input logic [LVL_W-1:0] code,
                                             input int unsigned depth);
    case (code)
      3'd0:    return depth / 8;
      3'd1:    return depth / 4;
      3'd2:    return depth / 2;
      3'd3:    return (depth * 3) / 4;
      default: return (depth * 7) / 8;
    endcase
  endfunction
endpackage

// File: rtl/uart_dma_tx_req.sv
module uart_dma_tx_req
  import uart_dma_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [CW-1:0]    count_i,
  output logic             single_o,
  output logic             burst_o
);
  logic [CW-1:0] thr;
  assign thr = CW'(lvl_thresh(lvl_i, DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      single_o <= 1'b0;
      burst_o  <= 1'b0;
    end else begin
      single_o <= en_i && (count_i < CW'(DEPTH));
      burst_o  <= en_i && (count_i < thr);
    end
  end
endmodule

// File: rtl/uart_dma_rx_req.sv
module uart_dma_rx_req
  import uart_dma_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             block_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [CW-1:0]    count_i,
  output logic             single_o,
  output logic             burst_o
);
  logic [CW-1:0] thr;
  logic          go;
  assign thr = CW'(lvl_thresh(lvl_i, DEPTH));
  assign go  = en_i && !block_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      single_o <= 1'b0;
      burst_o  <= 1'b0;
    end else begin
      single_o <= go && (count_i != '0);
      burst_o  <= go && (count_i >= thr);
    end
  end
endmodule

// File: rtl/uart_dma_int_stat.sv
module uart_dma_int_stat #(
  parameter int unsigned NB = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] set_i,
  input  logic          clr_we_i,
  input  logic [NB-1:0] clr_i,
  output logic [NB-1:0] stat_o,
  output logic [NB-1:0] stat_nxt_o
);
  for (genvar b = 0; b < NB; b++) begin : g_bit
    // set has priority over a same-cycle clear
    assign stat_nxt_o[b] = set_i[b] | (stat_o[b] & ~(clr_we_i & clr_i[b]));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_o[b] <= 1'b0;
      else         stat_o[b] <= stat_nxt_o[b];
    end
  end
endmodule

// File: rtl/uart_dma_req.sv
module uart_dma_req
  import uart_dma_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              uart_en_i,
  input  logic              tx_dma_en_i,
  input  logic              rx_dma_en_i,
  input  logic              dma_on_err_i,
  input  logic [LVL_W-1:0]  tx_lvl_i,
  input  logic [LVL_W-1:0]  rx_lvl_i,
  input  logic [CW-1:0]     tx_count_i,
  input  logic [CW-1:0]     rx_count_i,
  input  logic [ERR_W-1:0]  rx_err_i,
  input  logic              tx_done_i,
  input  logic              rx_done_i,
  input  logic              icr_we_i,
  input  logic [STAT_W-1:0] icr_data_i,
  output logic              tx_single_o,
  output logic              tx_burst_o,
  output logic              rx_single_o,
  output logic              rx_burst_o,
  output logic [STAT_W-1:0] int_status_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] stat_set, stat_nxt;
  logic              rx_block;
  logic              irq_q;

  assign stat_set = {rx_done_i, tx_done_i, rx_err_i};

  uart_dma_int_stat #(.NB(STAT_W)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (stat_set),
    .clr_we_i   (icr_we_i),
    .clr_i      (icr_data_i),
    .stat_o     (int_status_o),
    .stat_nxt_o (stat_nxt)
  );

  // block from post-edge error state so error and clear take effect in one cycle
  assign rx_block = dma_on_err_i && (|stat_nxt[ERR_W-1:0]);

  uart_dma_tx_req #(.DEPTH(FIFO_DEPTH)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (uart_en_i && tx_dma_en_i),
    .lvl_i    (tx_lvl_i),
    .count_i  (tx_count_i),
    .single_o (tx_single_o),
    .burst_o  (tx_burst_o)
  );

  uart_dma_rx_req #(.DEPTH(FIFO_DEPTH)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (uart_en_i && rx_dma_en_i),
    .block_i  (rx_block),
    .lvl_i    (rx_lvl_i),
    .count_i  (rx_count_i),
    .single_o (rx_single_o),
    .burst_o  (rx_burst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |stat_nxt;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/uart_dma_req_chk.sv
module uart_dma_req_chk
  import uart_dma_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              uart_en_i,
  input logic              tx_dma_en_i,
  input logic              rx_dma_en_i,
  input logic              dma_on_err_i,
  input logic [CW-1:0]     tx_count_i,
  input logic [CW-1:0]     rx_count_i,
  input logic [ERR_W-1:0]  rx_err_i,
  input logic              tx_done_i,
  input logic              icr_we_i,
  input logic [STAT_W-1:0] icr_data_i,
  input logic              tx_single_o,
  input logic              tx_burst_o,
  input logic              rx_single_o,
  input logic              rx_burst_o,
  input logic [STAT_W-1:0] int_status_o,
  input logic              irq_o
);
  AST_TX_FREE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uart_en_i && tx_dma_en_i && tx_count_i < CW'(FIFO_DEPTH)) |=> tx_single_o); // R2
  AST_TX_FULL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_count_i == CW'(FIFO_DEPTH)) |=> !tx_single_o && !tx_burst_o); // R3
  AST_RX_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uart_en_i && rx_dma_en_i && !dma_on_err_i && rx_count_i != '0) |=> rx_single_o); // R4
  AST_UART_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uart_en_i |=> !(tx_single_o || tx_burst_o || rx_single_o || rx_burst_o)); // R6
  AST_ERR_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rx_err_i) |=> (|int_status_o[ERR_W-1:0])); // R7
  AST_ERR_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_on_err_i && (|rx_err_i)) |=> !rx_single_o && !rx_burst_o); // R8
  AST_W1C_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (icr_we_i && icr_data_i[BIT_TX_DONE] && !tx_done_i) |=> !int_status_o[BIT_TX_DONE]); // R9
  AST_DONE_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |=> irq_o && int_status_o[BIT_TX_DONE]); // R10
endmodule

bind uart_dma_req uart_dma_req_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .uart_en_i(uart_en_i), .tx_dma_en_i(tx_dma_en_i),
  .rx_dma_en_i(rx_dma_en_i), .dma_on_err_i(dma_on_err_i), .tx_count_i(tx_count_i),
  .rx_count_i(rx_count_i), .rx_err_i(rx_err_i), .tx_done_i(tx_done_i),
  .icr_we_i(icr_we_i), .icr_data_i(icr_data_i), .tx_single_o(tx_single_o),
  .tx_burst_o(tx_burst_o), .rx_single_o(rx_single_o), .rx_burst_o(rx_burst_o),
  .int_status_o(int_status_o), .irq_o(irq_o)
);

// File: tb/sim_uart_dma_req.sv
module sim_uart_dma_req;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uart_en = 0, tx_en = 0, rx_en = 0, on_err = 0;
  logic [2:0] tx_lvl = 0, rx_lvl = 0;
  logic [CW-1:0] tx_cnt = 0, rx_cnt = 0;
  logic [3:0] rx_err = 0;
  logic tx_done = 0, rx_done = 0, icr_we = 0;
  logic [5:0] icr_data = 0;
  logic tx_s, tx_b, rx_s, rx_b, irq;
  logic [5:0] stat;

  int checks = 0, failures = 0;
  logic [5:0] m_stat = 0;

  typedef struct {
    logic ts, tb, rs, rb, irq;
    logic [5:0] st;
    string tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_dma_req #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .uart_en_i(uart_en), .tx_dma_en_i(tx_en),
    .rx_dma_en_i(rx_en), .dma_on_err_i(on_err), .tx_lvl_i(tx_lvl), .rx_lvl_i(rx_lvl),
    .tx_count_i(tx_cnt), .rx_count_i(rx_cnt), .rx_err_i(rx_err), .tx_done_i(tx_done),
    .rx_done_i(rx_done), .icr_we_i(icr_we), .icr_data_i(icr_data),
    .tx_single_o(tx_s), .tx_burst_o(tx_b), .rx_single_o(rx_s), .rx_burst_o(rx_b),
    .int_status_o(stat), .irq_o(irq)
  );

  function automatic int thr(input logic [2:0] c);
    case (c)
      3'd0: return 2; 3'd1: return 4; 3'd2: return 8; 3'd3: return 12;
      default: return 14;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: called at negedge with inputs set; pushes expectation for next edge
  task automatic step(input string tag);
    exp_t e;
    logic blk, te, re;
    m_stat = (m_stat & ~(icr_we ? icr_data : 6'd0)) | {rx_done, tx_done, rx_err};
    blk = on_err && (|m_stat[3:0]);
    te = uart_en && tx_en;
    re = uart_en && rx_en && !blk;
    e.ts = te && (int'(tx_cnt) < DEPTH);
    e.tb = te && (int'(tx_cnt) < thr(tx_lvl));
    e.rs = re && (rx_cnt != 0);
    e.rb = re && (int'(rx_cnt) >= thr(rx_lvl));
    e.st = m_stat;
    e.irq = |m_stat;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    rx_err = 0; tx_done = 0; rx_done = 0; icr_we = 0; icr_data = 0;
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, "/R2"}, "tx_single", tx_s, e.ts);
      chk({e.tag, "/R3"}, "tx_burst", tx_b, e.tb);
      chk({e.tag, "/R4"}, "rx_single", rx_s, e.rs);
      chk({e.tag, "/R5"}, "rx_burst", rx_b, e.rb);
      chk({e.tag, "/R7"}, "status", stat, e.st);
      chk({e.tag, "/R10"}, "irq", irq, e.irq);
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    uart_en = 1; tx_en = 1; rx_en = 1; tx_cnt = 3; rx_cnt = 5;
    #(CLK_PERIOD * 2 + 2);
    // R1: reset state despite active inputs
    chk("R1", "reqs", {tx_s, tx_b, rx_s, rx_b}, 0);
    chk("R1", "status", stat, 0);
    chk("R1", "irq", irq, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    // R2/R3 transmit thresholds
    tx_lvl = 2; tx_cnt = 0;  rx_cnt = 0; step("R2_empty");
    tx_cnt = 16;                         step("R2_full");
    tx_lvl = 4; tx_cnt = 15;             step("R3_15_l4");
    tx_cnt = 13;                         step("R3_13_l4");
    tx_lvl = 2; tx_cnt = 7;              step("R3_7_l2");
    tx_cnt = 8;                          step("R3_8_l2");
    tx_lvl = 7; tx_cnt = 14;             step("R3_code7");
    tx_lvl = 0; tx_cnt = 1;              step("R3_l0");
    // R4/R5 receive thresholds
    rx_lvl = 0; rx_cnt = 1;              step("R4_one");
    rx_cnt = 2;                          step("R5_l0");
    rx_lvl = 3; rx_cnt = 11;             step("R5_11_l3");
    rx_cnt = 12;                         step("R5_12_l3");
    rx_lvl = 6; rx_cnt = 16;             step("R5_code6");
    // R6 gating
    tx_en = 0;                           step("R6_txoff");
    tx_en = 1; rx_en = 0;                step("R6_rxoff");
    rx_en = 1; uart_en = 0;              step("R6_uartoff");
    uart_en = 1;                         step("R6_back");
    // R7/R8 no blocking when error stop is off
    on_err = 0; rx_err = 4'b0010;        step("R8_noblock");
    step("R7_hold");
    icr_we = 1; icr_data = 6'b000010;    step("R9_clr_pe");
    // R8 blocking
    on_err = 1; rx_err = 4'b0001;        step("R8_err");
    step("R8_held");
    icr_we = 1; icr_data = 6'b000100;    step("R8_other_clr");
    rx_err = 4'b1000; icr_we = 1; icr_data = 6'b000001; step("R8_ovr_new");
    icr_we = 1; icr_data = 6'b001000;    step("R8_release");
    // R10 completion, R9 set wins
    tx_done = 1;                         step("R10_txdone");
    rx_done = 1;                         step("R10_rxdone");
    tx_done = 1; icr_we = 1; icr_data = 6'b110000; step("R9_setwins");
    icr_we = 1; icr_data = 6'b111111;    step("R9_clr_all");
    step("R9_idle");

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule